// File: doc/BRIEF.md
# Abort Routing and Fault Capture

This block sorts the abort reports of a processor's memory accesses into exception requests and records the details of each abort in banked fault registers. Three reporters feed it, each through its own report lane: the address-translation and permission checker, the debug breakpoint/watchpoint unit, and the external memory system. A report gives the access kind, the address, a status code, a precise flag and a flag saying the abort happened during a translation table walk. The block also receives the core's security state, a configuration bit that sends external aborts to the secure monitor, and the core's mask for imprecise aborts.

A data access or a cache maintenance abort raises a data-abort request at once. An instruction-fetch abort does not raise anything when it is reported. It is stored as a tag on the instruction slot that the fetch fills, and it raises a prefetch-abort request only if the core later executes that slot. A pipeline flush removes all tags. An external data abort that is imprecise is held as pending until the mask allows it. Each fault register has two copies, one secure and one non-secure, and all copies can be read directly at the ports.

Top module: `abort_router`

## Requirements
- R1: An instruction-fetch report (access code 2'b00) creates a tag only for the slot named by `fetch_slot_i`, and only in a cycle with `fetch_vld_i` high. A fetch report by itself never raises an exception request. A fetch report while `fetch_vld_i` is low has no effect.
- R2: Executing a tagged slot (`exec_vld_i`) raises `pabt_o` for one cycle, in the cycle after the execute. On the same clock edge, the instruction fault status and address registers are loaded with the saved status and address. The bank used is the core's security state at fetch time. The tag of that slot is then cleared.
- R3: `flush_i` clears every slot tag. A later execute of a slot that was flushed raises nothing and leaves the instruction fault registers unchanged.
- R4: A data (2'b01) or cache maintenance (2'b10) report raises `dabt_o` in the next cycle and writes the data fault status register. The data fault address register is loaded only if the source is not external, or if the walk flag is set. An external abort outside a walk leaves the address register unchanged.
- R5: An external data report that is neither precise nor in a walk sets a pending flag. The flag is held while `imp_mask_i` is high. Once the mask is low, the pending abort is taken: the data fault status is written in the bank of the core's state at arrival, and the data fault address is not written. A further imprecise report that arrives while one is pending is dropped.
- R6: With `trap_ext_i` high, every external abort (data, imprecise or fetch) raises `mon_o` in place of `dabt_o` or `pabt_o`. Only the secure copies (bank 0) are written in that case.
- R7: In every other case, the bank written follows `core_ns_i`: 0 selects the secure copy (index 0) and 1 selects the non-secure copy (index 1). This holds for non-external aborts even when `trap_ext_i` is high.
- R8: The priority order is a precise data abort, then a pending imprecise abort, then a prefetch abort. A loser stays pending or tagged, and its registers are not written. At most one of `dabt_o`, `pabt_o` and `mon_o` is high in any cycle.
- R9: When several sources report the same access class in one cycle, the lowest lane wins: lane 0 is translation, lane 1 is debug and lane 2 is external.
- R10: After reset, all fault registers are zero, all tags are clear, nothing is pending and no exception request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_vld_i | input | 3 | Report valid for each lane (0 translation, 1 debug, 2 external) |
| src_acc_i | input | 3x2 | Access kind for each lane: 00 fetch, 01 data, 10 cache maintenance |
| src_addr_i | input | 3xAW | Faulting address for each lane |
| src_stat_i | input | 3xSW | Status code for each lane |
| src_precise_i | input | 3 | Precise flag for each lane |
| src_walk_i | input | 3 | Abort happened during a translation walk, for each lane |
| fetch_vld_i | input | 1 | A fetch is filling a slot this cycle |
| fetch_slot_i | input | log2(NSLOT) | Slot filled by the fetch |
| exec_vld_i | input | 1 | The core executes a slot this cycle |
| exec_slot_i | input | log2(NSLOT) | Slot being executed |
| flush_i | input | 1 | Pipeline flush; clears all tags |
| core_ns_i | input | 1 | Core security state (1 = non-secure) |
| trap_ext_i | input | 1 | Route external aborts to the secure monitor |
| imp_mask_i | input | 1 | Imprecise abort mask |
| dabt_o | output | 1 | Data-abort request |
| pabt_o | output | 1 | Prefetch-abort request |
| mon_o | output | 1 | Secure monitor trap request |
| dfsr_o | output | 2xSW | Data fault status, copy [0] secure and copy [1] non-secure |
| dfar_o | output | 2xAW | Data fault address, both copies |
| ifsr_o | output | 2xSW | Instruction fault status, both copies |
| ifar_o | output | 2xAW | Instruction fault address, both copies |

## Verification
The assertions check four things on every cycle. At most one exception request is high. A monitor trap never changes a non-secure copy. An external abort outside a walk leaves the data address copies unchanged. A masked pending abort stays pending. They also check that tags appear only from a valid fetch, that a flush empties every tag, and that a prefetch request always follows an execute. Only the directed scenarios can show the deferred timing of a prefetch abort and that a flushed or unfetched slot stays silent. They also show which bank each register value lands in, lane priority, and that an imprecise abort is released with its status from the time it arrived.

// File: rtl/abort_pkg.sv
package abort_pkg;
  localparam int NSRC    = 3;
  localparam int SIW     = $clog2(NSRC);
  localparam int SRC_MMU = 0;
  localparam int SRC_DBG = 1;
  localparam int SRC_EXT = 2;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'b00,
    ACC_DATA   = 2'b01,
    ACC_CMAINT = 2'b10,
    ACC_RSVD   = 2'b11
  } acc_e;
endpackage

// File: rtl/abort_select.sv
module abort_select
  import abort_pkg::*;
#(
  parameter bit FETCH_SIDE = 1'b0
) (
  input  logic [NSRC-1:0]      vld_i,
  input  logic [NSRC-1:0][1:0] acc_i,
  output logic                 hit_o,
  output logic [SIW-1:0]       idx_o
);
  logic [NSRC-1:0] match;

  for (genvar g = 0; g < NSRC; g++) begin : g_match
    if (FETCH_SIDE) begin : g_f
      assign match[g] = vld_i[g] && (acc_i[g] == ACC_FETCH);
    end else begin : g_d
      assign match[g] = vld_i[g] && ((acc_i[g] == ACC_DATA) || (acc_i[g] == ACC_CMAINT));
    end
  end

  // lowest lane wins
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (match[i]) idx_o = SIW'(i);
    end
  end
endmodule

// File: rtl/abort_slot_tags.sv
module abort_slot_tags #(
  parameter  int NSLOT = 4,
  parameter  int AW    = 32,
  parameter  int SW    = 5,
  localparam int SLW   = $clog2(NSLOT)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           flush_i,
  input  logic           wr_i,
  input  logic [SLW-1:0] wr_slot_i,
  input  logic           wr_hit_i,
  input  logic           wr_ext_i,
  input  logic           wr_ns_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [SW-1:0]  wr_stat_i,
  input  logic           clr_i,
  input  logic [SLW-1:0] clr_slot_i,
  input  logic [SLW-1:0] rd_slot_i,
  output logic           rd_vld_o,
  output logic           rd_ext_o,
  output logic           rd_ns_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic [SW-1:0]  rd_stat_o
);
  logic [NSLOT-1:0]         vld_q;
  logic [NSLOT-1:0]         ext_q;
  logic [NSLOT-1:0]         ns_q;
  logic [NSLOT-1:0][AW-1:0] addr_q;
  logic [NSLOT-1:0][SW-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      ext_q  <= '0;
      ns_q   <= '0;
      addr_q <= '0;
      stat_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else begin
      if (clr_i) vld_q[clr_slot_i] <= 1'b0;
      if (wr_i) begin
        vld_q[wr_slot_i]  <= wr_hit_i;
        ext_q[wr_slot_i]  <= wr_ext_i;
        ns_q[wr_slot_i]   <= wr_ns_i;
        addr_q[wr_slot_i] <= wr_addr_i;
        stat_q[wr_slot_i] <= wr_stat_i;
      end
    end
  end

  assign rd_vld_o  = vld_q[rd_slot_i];
  assign rd_ext_o  = ext_q[rd_slot_i];
  assign rd_ns_o   = ns_q[rd_slot_i];
  assign rd_addr_o = addr_q[rd_slot_i];
  assign rd_stat_o = stat_q[rd_slot_i];

  p_flush_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q == '0));

  p_tag_set_by_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(vld_q & ~$past(vld_q))) |-> $past(wr_i && wr_hit_i && !flush_i));
endmodule

// File: rtl/abort_fault_regs.sv
module abort_fault_regs #(
  parameter int AW = 32,
  parameter int SW = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_dfsr_i,
  input  logic               wr_dfar_i,
  input  logic               wr_ifault_i,
  input  logic               bank_i,
  input  logic [SW-1:0]      stat_i,
  input  logic [AW-1:0]      addr_i,
  output logic [1:0][SW-1:0] dfsr_o,
  output logic [1:0][AW-1:0] dfar_o,
  output logic [1:0][SW-1:0] ifsr_o,
  output logic [1:0][AW-1:0] ifar_o
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == b[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dfsr_o[b] <= '0;
        dfar_o[b] <= '0;
        ifsr_o[b] <= '0;
        ifar_o[b] <= '0;
      end else if (sel) begin
        if (wr_dfsr_i) dfsr_o[b] <= stat_i;
        if (wr_dfar_i) dfar_o[b] <= addr_i;
        if (wr_ifault_i) begin
          ifsr_o[b] <= stat_i;
          ifar_o[b] <= addr_i;
        end
      end
    end
  end

  p_one_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_dfsr_i, wr_ifault_i}));

  p_dfar_with_dfsr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dfar_i |-> wr_dfsr_i);
endmodule

// File: rtl/abort_router.sv
module abort_router
  import abort_pkg::*;
#(
  parameter  int NSLOT = 4,
  parameter  int AW    = 32,
  parameter  int SW    = 5,
  localparam int SLW   = $clog2(NSLOT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSRC-1:0]      src_vld_i,
  input  logic [NSRC-1:0][1:0] src_acc_i,
  input  logic [NSRC-1:0][AW-1:0] src_addr_i,
  input  logic [NSRC-1:0][SW-1:0] src_stat_i,
  input  logic [NSRC-1:0]      src_precise_i,
  input  logic [NSRC-1:0]      src_walk_i,
  input  logic                 fetch_vld_i,
  input  logic [SLW-1:0]       fetch_slot_i,
  input  logic                 exec_vld_i,
  input  logic [SLW-1:0]       exec_slot_i,
  input  logic                 flush_i,
  input  logic                 core_ns_i,
  input  logic                 trap_ext_i,
  input  logic                 imp_mask_i,
  output logic                 dabt_o,
  output logic                 pabt_o,
  output logic                 mon_o,
  output logic [1:0][SW-1:0]   dfsr_o,
  output logic [1:0][AW-1:0]   dfar_o,
  output logic [1:0][SW-1:0]   ifsr_o,
  output logic [1:0][AW-1:0]   ifar_o
);
  logic           d_hit, f_hit;
  logic [SIW-1:0] d_idx, f_idx;

  abort_select #(.FETCH_SIDE(1'b0)) u_sel_data (
    .vld_i(src_vld_i), .acc_i(src_acc_i), .hit_o(d_hit), .idx_o(d_idx)
  );
  abort_select #(.FETCH_SIDE(1'b1)) u_sel_fetch (
    .vld_i(src_vld_i), .acc_i(src_acc_i), .hit_o(f_hit), .idx_o(f_idx)
  );

  logic d_ext, d_walk, d_imp, f_ext;
  assign d_ext  = (d_idx == SIW'(SRC_EXT));
  assign d_walk = src_walk_i[d_idx];
  assign d_imp  = d_ext && !src_precise_i[d_idx] && !d_walk;
  assign f_ext  = (f_idx == SIW'(SRC_EXT));

  logic          t_vld, t_ext, t_ns;
  logic [AW-1:0] t_addr;
  logic [SW-1:0] t_stat;
  logic          take_pd, imp_arr, take_imp, take_pf;

  abort_slot_tags #(.NSLOT(NSLOT), .AW(AW), .SW(SW)) u_tags (
    .clk_i, .rst_ni, .flush_i,
    .wr_i(fetch_vld_i), .wr_slot_i(fetch_slot_i), .wr_hit_i(f_hit),
    .wr_ext_i(f_ext), .wr_ns_i(core_ns_i),
    .wr_addr_i(src_addr_i[f_idx]), .wr_stat_i(src_stat_i[f_idx]),
    .clr_i(take_pf), .clr_slot_i(exec_slot_i), .rd_slot_i(exec_slot_i),
    .rd_vld_o(t_vld), .rd_ext_o(t_ext), .rd_ns_o(t_ns),
    .rd_addr_o(t_addr), .rd_stat_o(t_stat)
  );

  // imprecise external data abort holding
  logic          imp_pend_q, imp_ns_q;
  logic [SW-1:0] imp_stat_q;

  assign take_pd  = d_hit && !d_imp;
  assign imp_arr  = d_hit && d_imp;
  assign take_imp = imp_pend_q && !imp_mask_i && !take_pd;
  assign take_pf  = exec_vld_i && t_vld && !take_pd && !take_imp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imp_pend_q <= 1'b0;
      imp_ns_q   <= 1'b0;
      imp_stat_q <= '0;
    end else if (imp_arr && (!imp_pend_q || take_imp)) begin
      imp_pend_q <= 1'b1;
      imp_ns_q   <= core_ns_i;
      imp_stat_q <= src_stat_i[d_idx];
    end else if (take_imp) begin
      imp_pend_q <= 1'b0;
    end
  end

  // routing and bank choice
  logic          bank, wr_dfsr, wr_dfar;
  logic [SW-1:0] w_stat;
  logic [AW-1:0] w_addr;
  logic          dabt_d, pabt_d, mon_d;

  always_comb begin
    wr_dfsr = take_pd || take_imp;
    wr_dfar = take_pd && (!d_ext || d_walk);
    if (take_pd) begin
      bank   = (d_ext && trap_ext_i) ? 1'b0 : core_ns_i;
      w_stat = src_stat_i[d_idx];
      w_addr = src_addr_i[d_idx];
    end else if (take_imp) begin
      bank   = trap_ext_i ? 1'b0 : imp_ns_q;
      w_stat = imp_stat_q;
      w_addr = '0;
    end else begin
      bank   = (t_ext && trap_ext_i) ? 1'b0 : t_ns;
      w_stat = t_stat;
      w_addr = t_addr;
    end
    mon_d  = (take_pd && d_ext && trap_ext_i) || (take_imp && trap_ext_i) ||
             (take_pf && t_ext && trap_ext_i);
    dabt_d = (take_pd && !(d_ext && trap_ext_i)) || (take_imp && !trap_ext_i);
    pabt_d = take_pf && !(t_ext && trap_ext_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dabt_o <= 1'b0;
      pabt_o <= 1'b0;
      mon_o  <= 1'b0;
    end else begin
      dabt_o <= dabt_d;
      pabt_o <= pabt_d;
      mon_o  <= mon_d;
    end
  end

  abort_fault_regs #(.AW(AW), .SW(SW)) u_regs (
    .clk_i, .rst_ni,
    .wr_dfsr_i(wr_dfsr), .wr_dfar_i(wr_dfar), .wr_ifault_i(take_pf),
    .bank_i(bank), .stat_i(w_stat), .addr_i(w_addr),
    .dfsr_o, .dfar_o, .ifsr_o, .ifar_o
  );

  p_one_exc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dabt_o, pabt_o, mon_o}));

  p_far_kept_ext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_hit && d_ext && !d_walk) |=> $stable(dfar_o));

  p_trap_secure_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_o |-> ($stable(dfsr_o[1]) && $stable(dfar_o[1]) &&
               $stable(ifsr_o[1]) && $stable(ifar_o[1])));

  p_pabt_on_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pabt_o |-> $past(exec_vld_i));

  p_imp_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imp_pend_q && imp_mask_i) |=> imp_pend_q);
endmodule

// File: tb/abort_router_tb.sv
module abort_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0]         src_vld;
  logic [2:0][1:0]    src_acc;
  logic [2:0][AW-1:0] src_addr;
  logic [2:0][SW-1:0] src_stat;
  logic [2:0]         src_precise, src_walk;
  logic       fetch_vld, exec_vld, flush, core_ns, trap_ext, imp_mask;
  logic [1:0] fetch_slot, exec_slot;
  logic dabt, pabt, mon;
  logic [1:0][SW-1:0] dfsr, ifsr;
  logic [1:0][AW-1:0] dfar, ifar;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abort_router u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .src_vld_i(src_vld), .src_acc_i(src_acc), .src_addr_i(src_addr),
    .src_stat_i(src_stat), .src_precise_i(src_precise), .src_walk_i(src_walk),
    .fetch_vld_i(fetch_vld), .fetch_slot_i(fetch_slot),
    .exec_vld_i(exec_vld), .exec_slot_i(exec_slot), .flush_i(flush),
    .core_ns_i(core_ns), .trap_ext_i(trap_ext), .imp_mask_i(imp_mask),
    .dabt_o(dabt), .pabt_o(pabt), .mon_o(mon),
    .dfsr_o(dfsr), .dfar_o(dfar), .ifsr_o(ifsr), .ifar_o(ifar)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    src_vld = '0; src_acc = '0; src_addr = '0; src_stat = '0;
    src_precise = '0; src_walk = '0;
    fetch_vld = 0; fetch_slot = 0; exec_vld = 0; exec_slot = 0; flush = 0;
  endtask

  task automatic rpt(input int l, input logic [1:0] acc, input logic [AW-1:0] a,
                     input logic [SW-1:0] s, input logic prec, input logic walk);
    src_vld[l] = 1'b1; src_acc[l] = acc; src_addr[l] = a; src_stat[l] = s;
    src_precise[l] = prec; src_walk[l] = walk;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one cycle of stimulus, then the outputs are checked, then inputs idle
  task automatic step();
    tick(); idle_in();
  endtask

  task automatic exc(input string req, input logic [2:0] exp);
    chk(req, "exc{dabt,pabt,mon}", {dabt, pabt, mon}, exp);
  endtask

  task automatic t_reset();
    exc("R10", 3'b000);
    chk("R10", "dfsr", dfsr, 0); chk("R10", "dfar", dfar, 0);
    chk("R10", "ifsr", ifsr, 0); chk("R10", "ifar", ifar, 0);
  endtask

  task automatic t_data_ns();
    core_ns = 1; rpt(0, 2'b01, 32'h1000_0040, 5'h0D, 1, 0); step();
    exc("R4", 3'b100);
    chk("R4", "dfsr[1]", dfsr[1], 5'h0D); chk("R4", "dfar[1]", dfar[1], 32'h1000_0040);
    chk("R7", "dfsr[0]", dfsr[0], 0); chk("R7", "dfar[0]", dfar[0], 0);
    tick(); exc("R4", 3'b000);
  endtask

  task automatic t_cmaint_sec();
    core_ns = 0; rpt(1, 2'b10, 32'h2000_0080, 5'h02, 1, 0); step();
    exc("R4", 3'b100);
    chk("R7", "dfsr[0]", dfsr[0], 5'h02); chk("R7", "dfar[0]", dfar[0], 32'h2000_0080);
    chk("R7", "dfsr[1]", dfsr[1], 5'h0D);
  endtask

  task automatic t_ext_far();
    core_ns = 1; rpt(2, 2'b01, 32'h3000_0000, 5'h08, 1, 0); step();
    exc("R4", 3'b100);
    chk("R4", "dfsr[1] ext", dfsr[1], 5'h08);
    chk("R4", "dfar[1] kept", dfar[1], 32'h1000_0040);
    rpt(2, 2'b01, 32'h3000_1000, 5'h0C, 1, 1); step();
    exc("R4", 3'b100);
    chk("R4", "dfar[1] walk", dfar[1], 32'h3000_1000);
    chk("R4", "dfsr[1] walk", dfsr[1], 5'h0C);
  endtask

  task automatic t_fetch_defer();
    core_ns = 1; fetch_vld = 1; fetch_slot = 2;
    rpt(0, 2'b00, 32'h4000_0008, 5'h05, 1, 0); step();
    exc("R1", 3'b000); chk("R1", "ifsr[1]", ifsr[1], 0);
    tick(); exc("R1", 3'b000);
    exec_vld = 1; exec_slot = 2; step();
    exc("R2", 3'b010);
    chk("R2", "ifsr[1]", ifsr[1], 5'h05); chk("R2", "ifar[1]", ifar[1], 32'h4000_0008);
    chk("R2", "ifsr[0]", ifsr[0], 0);
    exec_vld = 1; exec_slot = 2; step();
    exc("R2", 3'b000);
  endtask

  task automatic t_fetch_no_vld();
    rpt(0, 2'b00, 32'h4400_0000, 5'h07, 1, 0); step();
    exec_vld = 1; exec_slot = 1; step();
    exc("R1", 3'b000); chk("R1", "ifsr[1]", ifsr[1], 5'h05);
  endtask

  task automatic t_flush();
    fetch_vld = 1; fetch_slot = 0; rpt(1, 2'b00, 32'h5000_0000, 5'h02, 1, 0); step();
    flush = 1; step();
    exec_vld = 1; exec_slot = 0; step();
    exc("R3", 3'b000);
    chk("R3", "ifsr[1]", ifsr[1], 5'h05); chk("R3", "ifar[1]", ifar[1], 32'h4000_0008);
  endtask

  task automatic t_trap();
    trap_ext = 1; core_ns = 1;
    rpt(2, 2'b01, 32'h6000_0000, 5'h16, 1, 1); step();
    exc("R6", 3'b001);
    chk("R6", "dfsr[0]", dfsr[0], 5'h16); chk("R6", "dfar[0]", dfar[0], 32'h6000_0000);
    chk("R6", "dfsr[1]", dfsr[1], 5'h0C); chk("R6", "dfar[1]", dfar[1], 32'h3000_1000);
    fetch_vld = 1; fetch_slot = 3; rpt(2, 2'b00, 32'h6000_0100, 5'h14, 1, 0); step();
    exec_vld = 1; exec_slot = 3; step();
    exc("R6", 3'b001);
    chk("R6", "ifsr[0]", ifsr[0], 5'h14); chk("R6", "ifar[0]", ifar[0], 32'h6000_0100);
    chk("R6", "ifsr[1]", ifsr[1], 5'h05);
    rpt(0, 2'b01, 32'h6100_0000, 5'h09, 1, 0); step();
    exc("R7", 3'b100);
    chk("R7", "dfsr[1]", dfsr[1], 5'h09); chk("R7", "dfar[1]", dfar[1], 32'h6100_0000);
    trap_ext = 0;
  endtask

  task automatic t_imprecise();
    imp_mask = 1; core_ns = 1;
    rpt(2, 2'b01, 32'h7000_0000, 5'h06, 0, 0); step();
    exc("R5", 3'b000);
    core_ns = 0; rpt(2, 2'b01, 32'h7000_0100, 5'h11, 0, 0); step();
    exc("R5", 3'b000);
    tick(); exc("R5", 3'b000); chk("R5", "dfsr[1] held", dfsr[1], 5'h09);
    imp_mask = 0; tick();
    exc("R5", 3'b100);
    chk("R5", "dfsr[1]", dfsr[1], 5'h06); chk("R5", "dfar[1]", dfar[1], 32'h6100_0000);
    chk("R5", "dfsr[0]", dfsr[0], 5'h16);
    tick(); exc("R5", 3'b000);
    trap_ext = 1; core_ns = 1;
    rpt(2, 2'b01, 32'h7100_0000, 5'h0A, 0, 0); step();
    tick(); exc("R6", 3'b001); chk("R6", "dfsr[0] imprecise", dfsr[0], 5'h0A);
    trap_ext = 0;
  endtask

  task automatic t_priority();
    core_ns = 1; fetch_vld = 1; fetch_slot = 3;
    rpt(0, 2'b00, 32'h8000_0000, 5'h03, 1, 0); step();
    exec_vld = 1; exec_slot = 3; rpt(0, 2'b01, 32'h8100_0000, 5'h01, 1, 0); step();
    exc("R8", 3'b100);
    chk("R8", "ifsr[1]", ifsr[1], 5'h05); chk("R8", "dfsr[1]", dfsr[1], 5'h01);
    exec_vld = 1; exec_slot = 3; step();
    exc("R8", 3'b010);
    chk("R8", "ifsr[1]", ifsr[1], 5'h03); chk("R8", "ifar[1]", ifar[1], 32'h8000_0000);
  endtask

  task automatic t_src_order();
    core_ns = 1;
    rpt(0, 2'b01, 32'h9000_0000, 5'h1A, 1, 0);
    rpt(2, 2'b01, 32'h9000_0100, 5'h1B, 1, 0); step();
    exc("R9", 3'b100);
    chk("R9", "dfsr[1]", dfsr[1], 5'h1A); chk("R9", "dfar[1]", dfar[1], 32'h9000_0000);
    rpt(1, 2'b10, 32'h9100_0000, 5'h1C, 1, 0);
    rpt(2, 2'b01, 32'h9200_0000, 5'h1D, 1, 1); step();
    chk("R9", "dfsr[1]", dfsr[1], 5'h1C); chk("R9", "dfar[1]", dfar[1], 32'h9100_0000);
  endtask

  initial begin
    idle_in(); core_ns = 0; trap_ext = 0; imp_mask = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();
    t_reset();
    t_data_ns();
    t_cmaint_sec();
    t_ext_far();
    t_fetch_defer();
    t_fetch_no_vld();
    t_flush();
    t_trap();
    t_imprecise();
    t_priority();
    t_src_order();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule